// File: doc/BRIEF.md
# Phase-Split Register File (2 Reads + 1 Write per Cycle)

This block is the integer register file of a pipelined processor core. Each processor cycle it returns two source operands and stores one result. The storage behind it is a plain two-port array, which can do two reads or one write at a time, not both. The block meets the three accesses by splitting every processor cycle into two phases. Both reads are done in the first phase. The single write is done in the second phase.

The block runs from one clock at twice the processor cycle rate. An internal phase flag alternates on every edge of that clock, and the flag is exported so that the surrounding pipeline can align to it. The read addresses are sampled at the edge that closes the read phase, and the operands are held steady on the outputs until the next such edge. The write fields are sampled at the edge that closes the write phase. A result written in one cycle is therefore seen by reads in the following cycle, and a read in the same cycle gets the old contents. Entry 0 can be configured as a hardwired zero.

Top module: `phased_regfile`

## Requirements
- R1: After reset the phase output is 0 (read phase). From then on it inverts on every rising clock edge: 0 means read phase and 1 means write phase.
- R2: While reset is high, and in the phase right after reset is released, both read data outputs are 0.
- R3: At the rising edge that ends a read phase, the two read data outputs load the entries named by the two read addresses. The addresses are independent and may be equal.
- R4: During the write phase both read data outputs keep their value. They change only at the edge that ends a read phase.
- R5: At the rising edge that ends a write phase, when the write enable is 1 and the write address is not 0, the write data is stored in the addressed entry.
- R6: A write made in one cycle is returned by reads in the next cycle. A read of the same entry in the same cycle returns the value it had before the write.
- R7: With the zero-register option enabled (the default), address 0 reads as 0 on both ports, and a write to address 0 changes no entry.
- R8: A write phase whose write enable is 0 leaves every entry unchanged.
- R9: The read addresses have no effect during the write phase, and the write enable, address and data have no effect during the read phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Double-rate clock, two edges per processor cycle |
| rst | input | 1 | Synchronous active-high reset |
| rd_addr_a | input | 5 | First read address, sampled at the end of the read phase |
| rd_addr_b | input | 5 | Second read address, sampled at the end of the read phase |
| wr_en | input | 1 | Write enable, sampled at the end of the write phase |
| wr_addr | input | 5 | Write address, sampled at the end of the write phase |
| wr_data | input | 32 | Write data, sampled at the end of the write phase |
| rd_data_a | output | 32 | First operand, held for a whole cycle |
| rd_data_b | output | 32 | Second operand, held for a whole cycle |
| phase | output | 1 | Current phase: 0 read, 1 write |

## Verification
The hardest case to reach is a read and a write that hit the same entry in one cycle. The read must return the old value, and the next cycle must return the new one. The random stimulus therefore often reuses the most recent write address as a read address, and it often picks address 0. In every phase the bench drives random junk on the fields that should be ignored in that phase. A wrong phase gate then corrupts data that later reads expose.

// File: rtl/rf_pkg.sv
package rf_pkg;
  typedef enum logic {
    PH_READ  = 1'b0,
    PH_WRITE = 1'b1
  } rf_phase_e;
endpackage

// File: rtl/rf_phase_gen.sv
module rf_phase_gen
  import rf_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  output rf_phase_e phase
);
  always_ff @(posedge clk) begin
    if (rst) phase <= PH_READ;
    else     phase <= (phase == PH_READ) ? PH_WRITE : PH_READ;
  end

  // R1: phase alternates on every edge outside reset
  p_phase_alt_r1: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> phase != $past(phase));
endmodule

// File: rtl/rf_port_arb.sv
module rf_port_arb
  import rf_pkg::*;
#(
  parameter int ADDR_W   = 5,
  parameter bit ZERO_REG = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  rf_phase_e         phase,
  input  logic [ADDR_W-1:0] rd_addr_a,
  input  logic [ADDR_W-1:0] rd_addr_b,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  output logic [ADDR_W-1:0] ram_addr_a,
  output logic [ADDR_W-1:0] ram_addr_b,
  output logic              ram_re,
  output logic              ram_we,
  output logic              zero_a,
  output logic              zero_b
);
  logic wr_allowed;

  generate
    if (ZERO_REG) begin : g_zero
      assign wr_allowed = (wr_addr != '0);
      always_ff @(posedge clk) begin
        if (rst) begin
          zero_a <= 1'b0;
          zero_b <= 1'b0;
        end else if (phase == PH_READ) begin
          zero_a <= (rd_addr_a == '0);
          zero_b <= (rd_addr_b == '0);
        end
      end
    end else begin : g_nozero
      assign wr_allowed = 1'b1;
      assign zero_a = 1'b0;
      assign zero_b = 1'b0;
    end
  endgenerate

  // Port A reads only; port B is shared: read address in read phase, write address in write phase
  always_comb begin
    ram_addr_a = rd_addr_a;
    ram_re     = (phase == PH_READ);
    ram_we     = (phase == PH_WRITE) && wr_en && wr_allowed;
    ram_addr_b = (phase == PH_WRITE) ? wr_addr : rd_addr_b;
  end
endmodule

// File: rtl/rf_storage.sv
module rf_storage #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 32,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              re,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr_a,
  input  logic [ADDR_W-1:0] addr_b,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] q_a,
  output logic [DATA_W-1:0] q_b
);
  logic [DATA_W-1:0] mem [DEPTH];

  // Write through port B
  always_ff @(posedge clk) begin
    if (we) mem[addr_b] <= wdata;
  end

  // Registered reads on both ports, with a synchronous reset on the output registers
  always_ff @(posedge clk) begin
    if (rst) begin
      q_a <= '0;
      q_b <= '0;
    end else if (re) begin
      q_a <= mem[addr_a];
      q_b <= mem[addr_b];
    end
  end

  // R9: the two ports never read and write in the same edge
  p_excl_access_r9: assert property (@(posedge clk) disable iff (rst)
    !(re && we));
endmodule

// File: rtl/phased_regfile.sv
module phased_regfile
  import rf_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 32,
  parameter bit ZERO_REG = 1'b1,
  localparam int ADDR_W  = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] rd_addr_a,
  input  logic [ADDR_W-1:0] rd_addr_b,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data_a,
  output logic [DATA_W-1:0] rd_data_b,
  output logic              phase
);
  rf_phase_e         ph;
  logic [ADDR_W-1:0] ram_addr_a, ram_addr_b;
  logic              ram_re, ram_we, zero_a, zero_b;
  logic [DATA_W-1:0] q_a, q_b;

  rf_phase_gen u_phase (
    .clk(clk), .rst(rst), .phase(ph)
  );

  rf_port_arb #(.ADDR_W(ADDR_W), .ZERO_REG(ZERO_REG)) u_arb (
    .clk(clk), .rst(rst), .phase(ph),
    .rd_addr_a(rd_addr_a), .rd_addr_b(rd_addr_b),
    .wr_en(wr_en), .wr_addr(wr_addr),
    .ram_addr_a(ram_addr_a), .ram_addr_b(ram_addr_b),
    .ram_re(ram_re), .ram_we(ram_we),
    .zero_a(zero_a), .zero_b(zero_b)
  );

  rf_storage #(.DATA_W(DATA_W), .DEPTH(NUM_REGS), .ADDR_W(ADDR_W)) u_mem (
    .clk(clk), .rst(rst), .re(ram_re), .we(ram_we),
    .addr_a(ram_addr_a), .addr_b(ram_addr_b), .wdata(wr_data),
    .q_a(q_a), .q_b(q_b)
  );

  assign rd_data_a = zero_a ? '0 : q_a;
  assign rd_data_b = zero_b ? '0 : q_b;
  assign phase     = ph;

  // R4: operands hold through the write phase
  p_hold_wphase_r4: assert property (@(posedge clk) disable iff (rst)
    ph == PH_WRITE |=> $stable(rd_data_a) && $stable(rd_data_b));

  // R5: the array is written only in the write phase
  p_we_wphase_r5: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> ph == PH_WRITE);

  // R2: outputs are clear right after reset
  p_reset_clear_r2: assert property (@(posedge clk)
    rst |=> rd_data_a == '0 && rd_data_b == '0);

  generate
    if (ZERO_REG) begin : g_zchk
      // R7: entry 0 is never written and always reads zero
      p_zero_nowrite_r7: assert property (@(posedge clk) disable iff (rst)
        ram_we |-> ram_addr_b != '0);
      p_zero_read_r7: assert property (@(posedge clk) disable iff (rst)
        ph == PH_READ && rd_addr_a == '0 |=> rd_data_a == '0);
    end
  endgenerate
endmodule

// File: tb/sim_phased_regfile.sv
module sim_phased_regfile;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  rd_addr_a = '0, rd_addr_b = '0, wr_addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data_a, rd_data_b;
  logic        phase;

  int checks = 0;
  int errors = 0;
  logic [31:0] model [32];
  logic [4:0]  last_wa = 5'd1;
  bit done = 1'b0;

  always #4 clk = ~clk;

  phased_regfile u0 (
    .clk(clk), .rst(rst), .rd_addr_a(rd_addr_a), .rd_addr_b(rd_addr_b),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_data_a(rd_data_a), .rd_data_b(rd_data_b), .phase(phase)
  );

  function automatic logic [31:0] exp_read(input logic [4:0] a);
    return (a == 5'd0) ? 32'd0 : model[a];
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One processor cycle. Starts at a negedge in the read phase.
  task automatic do_cycle(input logic [4:0] ra, input logic [4:0] rb, input logic we,
                          input logic [4:0] wa, input logic [31:0] wd, input string tag);
    logic [31:0] ea, eb, ha, hb;
    ea = exp_read(ra);
    eb = exp_read(rb);
    rd_addr_a = ra; rd_addr_b = rb;
    wr_en = 1'b1; wr_addr = 5'($urandom); wr_data = $urandom; // junk, R9
    @(posedge clk); @(negedge clk);
    chk(phase == 1'b1, "R1 phase write", {31'd0, phase}, 32'd1);
    chk(rd_data_a === ea, {tag, " port A"}, rd_data_a, ea);
    chk(rd_data_b === eb, {tag, " port B"}, rd_data_b, eb);
    ha = rd_data_a; hb = rd_data_b;
    rd_addr_a = 5'($urandom); rd_addr_b = 5'($urandom); // junk, R9
    wr_en = we; wr_addr = wa; wr_data = wd;
    @(posedge clk); @(negedge clk);
    chk(phase == 1'b0, "R1 phase read", {31'd0, phase}, 32'd0);
    chk(rd_data_a === ha && rd_data_b === hb, "R4 hold", rd_data_a ^ rd_data_b, ha ^ hb);
    if (we && wa != 5'd0) begin
      model[wa] = wd;
      last_wa = wa;
    end
  endtask

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 32; i++) model[i] = 32'd0;
    repeat (3) @(negedge clk);
    chk(rd_data_a == 0 && rd_data_b == 0, "R2 reset data", rd_data_a | rd_data_b, 32'd0);
    chk(phase == 1'b0, "R2 reset phase", {31'd0, phase}, 32'd0);
    rst = 1'b0;
    chk(rd_data_a == 0 && rd_data_b == 0, "R2 after release", rd_data_a | rd_data_b, 32'd0);

    // R5: fill all entries
    for (int i = 1; i < 32; i++)
      do_cycle(5'd0, 5'd0, 1'b1, 5'(i), 32'hA500_0000 | 32'(i * 3), "R5 fill");
    for (int i = 0; i < 32; i += 2)
      do_cycle(5'(i), 5'(i + 1), 1'b0, 5'd0, 32'd0, "R5 readback");

    // R6: same-cycle read sees old, next cycle sees new
    do_cycle(5'd7, 5'd7, 1'b1, 5'd7, 32'hDEAD_BEEF, "R6 same cycle old");
    do_cycle(5'd7, 5'd3, 1'b0, 5'd0, 32'd0, "R6 next cycle new");

    // R7: write to zero entry ignored, reads zero
    do_cycle(5'd0, 5'd0, 1'b1, 5'd0, 32'hFFFF_FFFF, "R7 zero write");
    do_cycle(5'd0, 5'd0, 1'b0, 5'd0, 32'd0, "R7 zero read");

    // R8: enable low leaves entry
    do_cycle(5'd5, 5'd5, 1'b0, 5'd5, 32'h1234_5678, "R8 en low");
    do_cycle(5'd5, 5'd0, 1'b0, 5'd0, 32'd0, "R8 unchanged");

    // R9: junk write during read phase (always driven), then check entry 9
    do_cycle(5'd9, 5'd9, 1'b0, 5'd9, 32'h0, "R9 ignore");
    do_cycle(5'd9, 5'd9, 1'b0, 5'd0, 32'h0, "R9 ignore");

    // R3: random traffic, biased to the last written address and zero
    for (int n = 0; n < 400; n++) begin
      logic [4:0] ra, rb;
      int sel;
      sel = int'($urandom % 4);
      ra = (sel == 0) ? last_wa : (sel == 1) ? 5'd0 : 5'($urandom);
      rb = ($urandom % 3 == 0) ? last_wa : 5'($urandom);
      do_cycle(ra, rb, 1'($urandom), ($urandom % 3 == 0) ? ra : 5'($urandom),
               $urandom, "R3 random");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule